// File: doc/BRIEF.md
# Half-Precision Floating-Point Compare Unit

This unit takes two binary16 operands and a five-bit function code, decides whether the selected relation holds between them, and returns a sixteen-bit lane mask. The mask is all ones when the relation holds and all zeros when it does not. Alongside the mask it reports an invalid-operation flag. That flag follows quiet rules for the equality compare and signaling rules for the ordering compares. It also reports an indication that the function code is not supported.

Operands enter through a valid/ready handshake. The result leaves one cycle later from an output register, which holds it until the consumer takes it. The absolute variants compare magnitudes: both sign bits are dropped before the comparison. Subnormals are compared exactly. Zeros of either sign are equal. Any NaN operand makes the relation unordered.

Top module: `hpcmp_unit`

## Requirements
- R1: Every delivered `out_mask` is either 16'hFFFF (relation holds) or 16'h0000 (it does not). The function codes are 5'h04 equal, 5'h14 greater-or-equal, 5'h1C greater-than, 5'h15 absolute greater-or-equal and 5'h1D absolute greater-than.
- R2: Equality holds for identical non-NaN encodings and between +0 (16'h0000) and -0 (16'h8000). For such a pair, greater-or-equal also holds and greater-than does not.
- R3: Greater-or-equal holds when a is greater than or equal to b, and greater-than holds only when a is strictly greater. Ordering is by signed value: a negative value orders below every positive value, and a larger magnitude orders lower among negative values. Subnormals (exponent 0) are ordered exactly, and infinities (exponent 31, mantissa 0) order above all finite values of the same sign.
- R4: The absolute codes clear bit 15 of both operands before comparing, so only the magnitudes decide the result.
- R5: If either operand is a NaN (exponent 31, mantissa nonzero), the mask is 16'h0000 for every function code.
- R6: Under the equality code, `out_invalid` is raised only when an operand is a signaling NaN: exponent 31, mantissa nonzero and mantissa bit 9 clear. A quiet NaN (mantissa bit 9 set) leaves the flag low.
- R7: Under the four ordering codes, `out_invalid` is raised whenever either operand is any NaN, quiet or signaling.
- R8: Any other function code returns mask 16'h0000 with `out_unsupported` high and `out_invalid` low. `out_unsupported` belongs to that single result only.
- R9: A result appears on the outputs in the cycle after a clock edge at which `in_valid` and `in_ready` are both high. `in_ready` is high exactly when the output register is empty or `out_ready` is high. While `out_valid` is high and `out_ready` is low, all outputs hold.
- R10: While `rst_n` is low, `out_valid` is low and `in_ready` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Operands and code are presented |
| in_ready | output | 1 | Unit can accept a new request |
| in_a | input | 16 | First operand, binary16 |
| in_b | input | 16 | Second operand, binary16 |
| in_func | input | 5 | Function code |
| out_valid | output | 1 | Result register holds a result |
| out_ready | input | 1 | Consumer takes the result |
| out_mask | output | 16 | All-ones or all-zeros relation mask |
| out_invalid | output | 1 | Invalid-operation exception |
| out_unsupported | output | 1 | Function code was not one of the five |

## Verification
The bench works on pairs that break naive integer comparison. These include +0 against -0, negative operands where the larger magnitude is the smaller value, subnormals next to the smallest normal, infinities next to the largest finite value, and the absolute codes with mixed signs. A design that compared raw bits would report -0 below +0 and order negatives backwards. A design that kept the sign in the absolute codes would fail the mixed-sign magnitude cases. Quiet and signaling NaNs go to every code, so that a design which mixed up the quiet and signaling rules raises or misses `out_invalid`. Any mask other than zero on a NaN also shows up. Random back-pressure on `out_ready` exposes a result register that drops, duplicates or alters a held result.

// File: rtl/hpcmp_pkg.sv
package hpcmp_pkg;
  localparam int FUNC_W = 5;

  typedef enum logic [FUNC_W-1:0] {
    OP_EQ  = 5'h04,
    OP_GE  = 5'h14,
    OP_AGE = 5'h15,
    OP_GT  = 5'h1C,
    OP_AGT = 5'h1D
  } cmp_op_e;

  typedef struct packed {
    logic use_eq;
    logic use_gt;
    logic strip;
    logic known;
  } op_decode_t;

  function automatic op_decode_t decode_op(input logic [FUNC_W-1:0] code);
    op_decode_t d;
    d = '0;
    unique case (code)
      OP_EQ:  begin d.known = 1'b1; d.use_eq = 1'b1; end
      OP_GE:  begin d.known = 1'b1; d.use_eq = 1'b1; d.use_gt = 1'b1; end
      OP_GT:  begin d.known = 1'b1; d.use_gt = 1'b1; end
      OP_AGE: begin d.known = 1'b1; d.use_eq = 1'b1; d.use_gt = 1'b1; d.strip = 1'b1; end
      OP_AGT: begin d.known = 1'b1; d.use_gt = 1'b1; d.strip = 1'b1; end
      default: d = '0;
    endcase
    return d;
  endfunction
endpackage

// File: rtl/hpcmp_classify.sv
module hpcmp_classify #(
  parameter int EXP_W = 5,
  parameter int MAN_W = 10,
  localparam int W = 1 + EXP_W + MAN_W
) (
  input  logic [W-1:0] x,
  output logic         is_nan,
  output logic         is_snan,
  output logic         is_zero
);
  logic [EXP_W-1:0] expo;
  logic [MAN_W-1:0] mant;

  assign expo = x[W-2 -: EXP_W];
  assign mant = x[MAN_W-1:0];

  always_comb begin
    is_nan  = (&expo) && (|mant);
    is_snan = is_nan && !mant[MAN_W-1];
    is_zero = (expo == '0) && (mant == '0);
  end
endmodule

// File: rtl/hpcmp_order.sv
module hpcmp_order #(
  parameter int EXP_W = 5,
  parameter int MAN_W = 10,
  localparam int W = 1 + EXP_W + MAN_W
) (
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  input  logic         strip,
  input  logic         both_zero,
  output logic         rel_eq,
  output logic         rel_gt
);
  function automatic logic mag_above(input logic [W-2:0] p, input logic [W-2:0] q);
    return p > q;
  endfunction

  logic         sa, sb;
  logic [W-2:0] ma, mb;

  assign sa = a[W-1] & ~strip;
  assign sb = b[W-1] & ~strip;
  assign ma = a[W-2:0];
  assign mb = b[W-2:0];

  always_comb begin
    rel_eq = both_zero || ((sa == sb) && (ma == mb));
    if (both_zero)       rel_gt = 1'b0;
    else if (sa != sb)   rel_gt = !sa;
    else if (sa)         rel_gt = mag_above(mb, ma);
    else                 rel_gt = mag_above(ma, mb);
  end
endmodule

// File: rtl/hpcmp_outreg.sv
module hpcmp_outreg #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic [W-1:0] d_mask,
  input  logic         d_invalid,
  input  logic         d_unsup,
  input  logic         take,
  output logic         full,
  output logic [W-1:0] q_mask,
  output logic         q_invalid,
  output logic         q_unsup
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      full      <= 1'b0;
      q_mask    <= '0;
      q_invalid <= 1'b0;
      q_unsup   <= 1'b0;
    end else begin
      if (load) begin
        full      <= 1'b1;
        q_mask    <= d_mask;
        q_invalid <= d_invalid;
        q_unsup   <= d_unsup;
      end else if (take) begin
        full      <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/hpcmp_unit.sv
module hpcmp_unit
  import hpcmp_pkg::*;
#(
  parameter int EXP_W = 5,
  parameter int MAN_W = 10,
  localparam int W = 1 + EXP_W + MAN_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [W-1:0]      in_a,
  input  logic [W-1:0]      in_b,
  input  logic [FUNC_W-1:0] in_func,
  output logic              out_valid,
  input  logic              out_ready,
  output logic [W-1:0]      out_mask,
  output logic              out_invalid,
  output logic              out_unsupported
);
  logic [1:0]   opnd_nan, opnd_snan, opnd_zero;
  logic [W-1:0] opnd [2];
  op_decode_t   dec;
  logic         rel_eq, rel_gt, holds, any_nan, any_snan;
  logic         nxt_invalid, fire;

  assign opnd[0] = in_a;
  assign opnd[1] = in_b;

  for (genvar g = 0; g < 2; g++) begin : g_cls
    hpcmp_classify #(.EXP_W(EXP_W), .MAN_W(MAN_W)) u_cls (
      .x       (opnd[g]),
      .is_nan  (opnd_nan[g]),
      .is_snan (opnd_snan[g]),
      .is_zero (opnd_zero[g])
    );
  end

  assign dec = decode_op(in_func);

  hpcmp_order #(.EXP_W(EXP_W), .MAN_W(MAN_W)) u_ord (
    .a         (in_a),
    .b         (in_b),
    .strip     (dec.strip),
    .both_zero (&opnd_zero),
    .rel_eq    (rel_eq),
    .rel_gt    (rel_gt)
  );

  always_comb begin
    any_nan     = |opnd_nan;
    any_snan    = |opnd_snan;
    holds       = dec.known && !any_nan &&
                  ((dec.use_eq && rel_eq) || (dec.use_gt && rel_gt));
    nxt_invalid = dec.known && ((dec.use_gt) ? any_nan : any_snan);
  end

  assign in_ready = !out_valid || out_ready;
  assign fire     = in_valid && in_ready;

  hpcmp_outreg #(.W(W)) u_out (
    .clk       (clk),
    .rst_n     (rst_n),
    .load      (fire),
    .d_mask    ({W{holds}}),
    .d_invalid (nxt_invalid),
    .d_unsup   (!dec.known),
    .take      (out_ready),
    .full      (out_valid),
    .q_mask    (out_mask),
    .q_invalid (out_invalid),
    .q_unsup   (out_unsupported)
  );
endmodule

// File: rtl/hpcmp_unit_chk.sv
module hpcmp_unit_chk
  import hpcmp_pkg::*;
#(
  parameter int W = 16
) (
  input logic              clk,
  input logic              rst_n,
  input logic              in_valid,
  input logic              in_ready,
  input logic [FUNC_W-1:0] in_func,
  input logic              out_valid,
  input logic              out_ready,
  input logic [W-1:0]      out_mask,
  input logic              out_invalid,
  input logic              out_unsupported,
  input logic [1:0]        opnd_nan,
  input logic [1:0]        opnd_snan
);
  logic hs, ord_code;
  assign hs       = in_valid && in_ready;
  assign ord_code = (in_func == OP_GE) || (in_func == OP_GT) ||
                    (in_func == OP_AGE) || (in_func == OP_AGT);

  p_mask_shape_r1: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> (out_mask == '0 || out_mask == '1));

  p_nan_zero_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (hs && |opnd_nan) |=> (out_mask == '0));

  p_eq_quiet_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (hs && in_func == OP_EQ && opnd_snan == 2'b00) |=> !out_invalid);

  p_ord_signal_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (hs && ord_code && |opnd_nan) |=> out_invalid);

  p_unsup_clean_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_unsupported) |-> (out_mask == '0 && !out_invalid));

  p_latency_r9: assert property (@(posedge clk) disable iff (!rst_n)
    hs |=> out_valid);

  p_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_mask) &&
                                   $stable(out_invalid) && $stable(out_unsupported)));
endmodule

bind hpcmp_unit hpcmp_unit_chk #(.W(W)) u_chk (
  .clk             (clk),
  .rst_n           (rst_n),
  .in_valid        (in_valid),
  .in_ready        (in_ready),
  .in_func         (in_func),
  .out_valid       (out_valid),
  .out_ready       (out_ready),
  .out_mask        (out_mask),
  .out_invalid     (out_invalid),
  .out_unsupported (out_unsupported),
  .opnd_nan        (opnd_nan),
  .opnd_snan       (opnd_snan)
);

// File: tb/hpcmp_unit_test.sv
`timescale 1ns/1ps
module hpcmp_unit_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic        in_ready;
  logic [15:0] in_a = '0, in_b = '0;
  logic [4:0]  in_func = '0;
  logic        out_valid;
  logic        out_ready = 1'b1;
  logic [15:0] out_mask;
  logic        out_invalid, out_unsupported;

  int checks = 0, fails = 0, cyc = 0, stall_mode = 0;
  logic [15:0] lfsr = 16'hACE1;

  typedef struct {
    logic [15:0] m;
    logic        inv;
    logic        uns;
    string       tag;
  } exp_t;
  exp_t q[$];

  always #10 clk = ~clk;

  hpcmp_unit uut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_a(in_a), .in_b(in_b), .in_func(in_func), .out_valid(out_valid),
    .out_ready(out_ready), .out_mask(out_mask), .out_invalid(out_invalid),
    .out_unsupported(out_unsupported)
  );

  function automatic bit is_nan(logic [15:0] x);
    return x[14:10] == 5'd31 && x[9:0] != 0;
  endfunction

  // value scaled by 2^24 as a signed integer; infinity is a huge constant
  function automatic longint scaled(logic [15:0] x, bit absv);
    longint mag;
    int e = int'(x[14:10]);
    if (e == 0)       mag = longint'(x[9:0]);
    else if (e == 31) mag = longint'(1) << 50;
    else              mag = longint'(1024 + int'(x[9:0])) << (e - 1);
    return (x[15] && !absv) ? -mag : mag;
  endfunction

  function automatic exp_t model(logic [15:0] a, logic [15:0] b, logic [4:0] f, string tag);
    exp_t r;
    bit nan = is_nan(a) || is_nan(b);
    bit sn  = (is_nan(a) && !a[9]) || (is_nan(b) && !b[9]);
    bit absv = (f == 5'h15) || (f == 5'h1D);
    longint va = scaled(a, absv), vb = scaled(b, absv);
    bit h;
    r.tag = tag; r.uns = 0;
    case (f)
      5'h04: begin h = (va == vb); r.inv = sn; end
      5'h14, 5'h15: begin h = (va >= vb); r.inv = nan; end
      5'h1C, 5'h1D: begin h = (va > vb); r.inv = nan; end
      default: begin h = 0; r.inv = 0; r.uns = 1; end
    endcase
    if (nan) h = 0;
    r.m = h ? 16'hFFFF : 16'h0000;
    return r;
  endfunction

  task automatic check(bit ok, string tag, string what, longint act, longint expv);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %h expected %h", tag, what, act, expv);
    end
  endtask

  always @(posedge clk) begin
    cyc++;
    lfsr <= {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
  end

  initial forever begin
    @(posedge clk); #1;
    out_ready = (stall_mode == 0) ? 1'b1 : lfsr[3] | lfsr[7];
  end

  always @(negedge clk) begin
    if (!rst_n) begin
      check(out_valid == 0, "R10", "out_valid in reset", out_valid, 0);
      check(in_ready == 1, "R10", "in_ready in reset", in_ready, 1);
    end else begin
      check(in_ready == (!out_valid || out_ready), "R9", "in_ready", in_ready,
            !out_valid || out_ready);
      if (out_valid) begin
        if (q.size() == 0) check(0, "R9", "unexpected result", 1, 0);
        else begin
          check(out_mask == q[0].m, q[0].tag, "mask", out_mask, q[0].m);
          check(out_invalid == q[0].inv, q[0].tag, "invalid", out_invalid, q[0].inv);
          check(out_unsupported == q[0].uns, q[0].tag, "unsupported",
                out_unsupported, q[0].uns);
          if (out_ready) void'(q.pop_front());
        end
      end else if (q.size() != 0) begin
        check(0, "R9", "missing result", 0, 1);
      end
    end
  end

  task automatic send(logic [15:0] a, logic [15:0] b, logic [4:0] f, string tag);
    @(posedge clk); #1;
    in_valid = 1; in_a = a; in_b = b; in_func = f;
    do @(negedge clk); while (!in_ready);
    @(posedge clk);
    q.push_back(model(a, b, f, tag));
    #1 in_valid = 0;
  endtask

  task automatic finish_run();
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  endtask

  initial begin
    repeat (60000) @(posedge clk);
    fails++; checks++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  localparam logic [15:0] POOL [16] = '{16'h0000, 16'h8000, 16'h3C00, 16'hBC00,
    16'h4000, 16'hC000, 16'h7C00, 16'hFC00, 16'h7BFF, 16'h0001, 16'h03FF,
    16'h0400, 16'h7E00, 16'h7D00, 16'h83FF, 16'hFBFF};
  localparam logic [4:0] CODES [5] = '{5'h04, 5'h14, 5'h15, 5'h1C, 5'h1D};

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1;
    // R1 / R2: signed zeros and identical values
    send(16'h0000, 16'h8000, 5'h04, "R2");
    send(16'h8000, 16'h0000, 5'h14, "R2");
    send(16'h0000, 16'h8000, 5'h1C, "R2");
    send(16'h3C00, 16'h3C00, 5'h04, "R1");
    send(16'h3C00, 16'h4000, 5'h04, "R1");
    // R3: ordering
    send(16'hC000, 16'hBC00, 5'h1C, "R3");
    send(16'hBC00, 16'hC000, 5'h1C, "R3");
    send(16'h0001, 16'h0000, 5'h1C, "R3");
    send(16'h03FF, 16'h0400, 5'h14, "R3");
    send(16'h7C00, 16'h7BFF, 5'h1C, "R3");
    send(16'hFC00, 16'hFBFF, 5'h14, "R3");
    send(16'h7C00, 16'h7C00, 5'h14, "R3");
    // R4: magnitudes
    send(16'hC000, 16'h3C00, 5'h1D, "R4");
    send(16'hC000, 16'h3C00, 5'h1C, "R4");
    send(16'hBC00, 16'h3C00, 5'h15, "R4");
    send(16'hBC00, 16'h3C00, 5'h1D, "R4");
    // R5..R7: NaNs
    send(16'h7E00, 16'h7E00, 5'h04, "R6");
    send(16'h3C00, 16'h7D00, 5'h04, "R6");
    send(16'hFE00, 16'h3C00, 5'h14, "R7");
    send(16'h3C00, 16'h7E00, 5'h1D, "R7");
    send(16'h7D00, 16'h0000, 5'h1C, "R5");
    // R8: unsupported codes
    send(16'h3C00, 16'h3C00, 5'h00, "R8");
    send(16'h7D00, 16'h3C00, 5'h05, "R8");
    send(16'h4000, 16'h3C00, 5'h1F, "R8");
    send(16'h3C00, 16'h3C00, 5'h04, "R8");
    // R9: back-pressure with a broad mix
    stall_mode = 1;
    for (int i = 0; i < 300; i++)
      send(POOL[lfsr[3:0]], POOL[lfsr[11:8]], CODES[int'(lfsr[6:4]) % 5], "R9");
    stall_mode = 0;
    for (int i = 0; i < 200 && q.size() != 0; i++) @(posedge clk);
    repeat (4) @(posedge clk);
    check(q.size() == 0, "R9", "results drained", q.size(), 0);
    finish_run();
  end
endmodule